// File: doc/BRIEF.md
# Distributed DRAM Refresh Scheduler

This block spreads refresh work evenly across every bank of a memory channel, so that no bank goes without one. The bank count of the channel is the product of the configured banks per rank, ranks per DIMM and DIMMs per channel. A programmable per-row refresh interval, in memory cycles, is divided by that count. The quotient sets how often a single-bank refresh is started. A typical setting is 1560 cycles: a 7.8 µs row interval at a 5 ns clock. A faster channel profile uses 3120 cycles.

A down-counter reloads with the quotient. Each time it expires, one refresh is owed to the next bank in rotation. Owed refreshes are held in a small saturating counter. While that counter is nonzero, the block raises a request toward the command scheduler, together with the DIMM, rank and bank fields of the target. The scheduler accepts one refresh per cycle by asserting grant. Each accepted refresh moves the target on by one bank. The timing of the refresh commands themselves belongs to the scheduler.

The configuration inputs are expected to change only while reset is asserted.

Top module: `refresh_sched`

## Requirements
- R1: During and after reset, until the first expiry, `ref_req` is 0, `pend_cnt` is 0, and `ref_bank`, `ref_rank` and `ref_dimm` are all 0.
- R2: The reload value is Q = floor(cfg_period / (cfg_banks × cfg_ranks × cfg_dimms)), forced to 1 when the quotient is 0. With no grants, `pend_cnt` first becomes 1 exactly Q clock edges after reset is released. Afterwards one more refresh is owed every Q edges.
- R3: Refresh targets follow a linear index that starts at 0 and advances by one per accepted refresh. `ref_bank` is the fastest field, then `ref_rank`, then `ref_dimm`. After bank cfg_banks-1 of rank cfg_ranks-1 of DIMM cfg_dimms-1, the index returns to all zeros. `ref_bank` is always below cfg_banks.
- R4: While `ref_req` is 1 and `ref_gnt` is 0, the three target fields hold their values.
- R5: `ref_req` is 1 exactly when `pend_cnt` is nonzero. A refresh is accepted in a cycle where both `ref_req` and `ref_gnt` are 1. Without a concurrent expiry, an acceptance lowers `pend_cnt` by one.
- R6: `pend_cnt` saturates at 8. Expiries that occur while it is 8 are dropped.
- R7: When an expiry and an acceptance fall in the same cycle, `pend_cnt` keeps its value and the target still advances by one.
- R8: `ref_gnt` asserted while `ref_req` is 0 has no effect: the target fields and `pend_cnt` are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_period | input | 16 | Per-row refresh interval in cycles |
| cfg_banks | input | 4 | Banks per rank (1 to 8) |
| cfg_ranks | input | 3 | Ranks per DIMM (1 to 4) |
| cfg_dimms | input | 3 | DIMMs per channel (1 to 4) |
| ref_gnt | input | 1 | Scheduler accepts the pending refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_bank | output | 3 | Target bank within the rank |
| ref_rank | output | 2 | Target rank within the DIMM |
| ref_dimm | output | 2 | Target DIMM within the channel |
| pend_cnt | output | 4 | Number of refreshes owed |

## Verification
The counter expiry and a scheduler acceptance can land in the same cycle. In that cycle the owed count must stay put while the bank pointer still steps. The bench provokes this on a short reload value. It withholds grant until one refresh is owed, then asserts grant for exactly the cycle in which the next expiry is due. It judges the result by `pend_cnt` staying unchanged while `ref_bank` moves on one. Every acceptance is also matched against a queue of targets that the bench derives from the configured geometry.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Total banks on the channel; a zero product is treated as one.
  function automatic int unsigned total_banks(input int unsigned b,
                                              input int unsigned r,
                                              input int unsigned d);
    int unsigned t;
    t = b * r * d;
    return (t == 0) ? 1 : t;
  endfunction

  // Countdown reload: interval split across banks, never below one cycle.
  function automatic int unsigned reload_of(input int unsigned period,
                                            input int unsigned banks);
    int unsigned q;
    q = period / banks;
    return (q == 0) ? 1 : q;
  endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] reload,
  output logic                tick
);
  logic [PERIOD_W-1:0] count;

  assign tick = rst_n && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= reload - 1'b1;
    else if (tick) count <= reload - 1'b1;
    else           count <= count - 1'b1;
  end

  AST_RELOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == reload - 1'b1)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (count == $past(count) - 1'b1)); // R2
endmodule

// File: rtl/refsched_pointer.sv
module refsched_pointer #(
  parameter int MAX_BANKS = 8,
  parameter int MAX_RANKS = 4,
  parameter int MAX_DIMMS = 4,
  localparam int BANK_IW = $clog2(MAX_BANKS),
  localparam int RANK_IW = $clog2(MAX_RANKS),
  localparam int DIMM_IW = $clog2(MAX_DIMMS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANK_IW:0]   cfg_banks,
  input  logic [RANK_IW:0]   cfg_ranks,
  input  logic [DIMM_IW:0]   cfg_dimms,
  input  logic               adv,
  output logic [BANK_IW-1:0] bank,
  output logic [RANK_IW-1:0] rank,
  output logic [DIMM_IW-1:0] dimm
);
  logic last_bank, last_rank, last_dimm;

  assign last_bank = (bank == BANK_IW'(cfg_banks - 1'b1));
  assign last_rank = (rank == RANK_IW'(cfg_ranks - 1'b1));
  assign last_dimm = (dimm == DIMM_IW'(cfg_dimms - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
      rank <= '0;
      dimm <= '0;
    end else if (adv) begin
      if (!last_bank) begin
        bank <= bank + 1'b1;
      end else begin
        bank <= '0;
        if (!last_rank) begin
          rank <= rank + 1'b1;
        end else begin
          rank <= '0;
          dimm <= last_dimm ? '0 : dimm + 1'b1;
        end
      end
    end
  end

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bank} < cfg_banks)); // R3

  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_bank && last_rank && last_dimm) |=>
      (bank == '0 && rank == '0 && dimm == '0)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({dimm, rank, bank})); // R4
endmodule

// File: rtl/refsched_pending.sv
module refsched_pending #(
  parameter int PEND_MAX = 8,
  localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fire,
  output logic [PEND_W-1:0] pend,
  output logic              req
);
  logic at_max;

  assign at_max = (pend == PEND_W'(PEND_MAX));
  assign req    = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      case ({tick, fire})
        2'b10:   if (!at_max) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= PEND_W'(PEND_MAX))); // R6

  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fire) |=> $stable(pend)); // R7

  AST_FIRE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !tick) |=> (pend == $past(pend) - 1'b1)); // R5
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int PERIOD_W  = 16,
  parameter int MAX_BANKS = 8,
  parameter int MAX_RANKS = 4,
  parameter int MAX_DIMMS = 4,
  parameter int PEND_MAX  = 8,
  localparam int BANK_IW = $clog2(MAX_BANKS),
  localparam int RANK_IW = $clog2(MAX_RANKS),
  localparam int DIMM_IW = $clog2(MAX_DIMMS),
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [BANK_IW:0]    cfg_banks,
  input  logic [RANK_IW:0]    cfg_ranks,
  input  logic [DIMM_IW:0]    cfg_dimms,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic [BANK_IW-1:0]  ref_bank,
  output logic [RANK_IW-1:0]  ref_rank,
  output logic [DIMM_IW-1:0]  ref_dimm,
  output logic [PEND_W-1:0]   pend_cnt
);
  import refsched_pkg::*;

  logic [PERIOD_W-1:0] reload_val;
  logic                expiry;
  logic                accept;

  assign reload_val = PERIOD_W'(reload_of(32'(cfg_period),
                        total_banks(32'(cfg_banks), 32'(cfg_ranks), 32'(cfg_dimms))));
  assign accept = ref_req && ref_gnt;

  refsched_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload_val), .tick(expiry)
  );

  refsched_pending #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk(clk), .rst_n(rst_n), .tick(expiry), .fire(accept),
    .pend(pend_cnt), .req(ref_req)
  );

  refsched_pointer #(.MAX_BANKS(MAX_BANKS), .MAX_RANKS(MAX_RANKS),
                     .MAX_DIMMS(MAX_DIMMS)) u_pointer (
    .clk(clk), .rst_n(rst_n), .cfg_banks(cfg_banks), .cfg_ranks(cfg_ranks),
    .cfg_dimms(cfg_dimms), .adv(accept),
    .bank(ref_bank), .rank(ref_rank), .dimm(ref_dimm)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req); // R5

  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> $stable({ref_dimm, ref_rank, ref_bank})); // R4

  AST_IDLE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && !ref_req) |=> $stable({ref_dimm, ref_rank, ref_bank})); // R8

  AST_EXPIRY_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && !accept) |=> ref_req); // R2
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_period = 16'd1560;
  logic [3:0]  cfg_banks = 4'd8;
  logic [2:0]  cfg_ranks = 3'd2;
  logic [2:0]  cfg_dimms = 3'd2;
  logic        auto_gnt = 1'b0;
  logic        man_gnt = 1'b0;
  logic        ref_gnt;
  logic        ref_req;
  logic [2:0]  ref_bank;
  logic [1:0]  ref_rank;
  logic [1:0]  ref_dimm;
  logic [3:0]  pend_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];

  assign ref_gnt = auto_gnt ? ref_req : man_gnt;

  refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_banks(cfg_banks),
    .cfg_ranks(cfg_ranks), .cfg_dimms(cfg_dimms), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_bank(ref_bank), .ref_rank(ref_rank),
    .ref_dimm(ref_dimm), .pend_cnt(pend_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected targets from the index decomposition of R3
  task automatic push_targets(input int n);
    int b, r, d, tot;
    b = cfg_banks; r = cfg_ranks; d = cfg_dimms; tot = b * r * d;
    for (int i = 0; i < n; i++) begin
      int k;
      k = i % tot;
      exp_q.push_back(((k / (b * r)) % d) * 256 + ((k / b) % r) * 16 + (k % b));
    end
  endtask

  // Monitor: every accepted refresh is compared against the queue (R3)
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && ref_req && ref_gnt) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected accept", 1, 0);
      end else begin
        check("R3 target order", ref_dimm * 256 + ref_rank * 16 + ref_bank,
              exp_q.pop_front());
      end
    end
  end

  task automatic do_reset(input int period, input int b, input int r, input int d);
    auto_gnt = 1'b0;
    man_gnt  = 1'b0;
    rst_n    = 1'b0;
    cfg_period = 16'(period);
    cfg_banks  = 4'(b);
    cfg_ranks  = 3'(r);
    cfg_dimms  = 3'(d);
    repeat (3) @(negedge clk);
    exp_q.delete();
    push_targets(200);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(output int at);
    while (!ref_req) @(negedge clk);
    at = cyc;
  endtask

  task automatic interval_test(input string tag, input int q, input int n);
    int t0, t1;
    auto_gnt = 1'b1;
    @(negedge clk);
    wait_req(t0);
    check({tag, " first request cycle"}, t0, q);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wait_req(t1);
      check({tag, " request spacing"}, t1 - t0, q);
      t0 = t1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0, pn;
    // R1: reset state
    do_reset(1560, 8, 2, 2);
    @(negedge clk);
    check("R1 req after reset", ref_req, 0);
    check("R1 pend after reset", pend_cnt, 0);
    check("R1 target after reset", ref_dimm * 256 + ref_rank * 16 + ref_bank, 0);

    // R2/R3: default geometry, Q = 1560/32 = 48, full wrap over 32 banks
    do_reset(1560, 8, 2, 2);
    interval_test("R2 default", 48, 40);

    // R2: faster profile, Q = 3120/32 = 97
    do_reset(3120, 8, 2, 2);
    interval_test("R2 fast", 97, 4);

    // R3: smaller geometry 4x1x2, Q = 100/8 = 12, wraps several times
    do_reset(100, 4, 1, 2);
    interval_test("R3 small", 12, 20);

    // R8: grant with no request has no effect
    do_reset(100, 4, 1, 2);
    man_gnt = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 pend idle grant", pend_cnt, 0);
    check("R8 target idle grant", ref_dimm * 256 + ref_rank * 16 + ref_bank, 0);
    man_gnt = 1'b0;

    // R6/R4/R5: withheld grant saturates and holds target
    do_reset(100, 4, 1, 2);
    repeat (12 * 10 + 2) @(negedge clk);
    check("R6 pend saturated", pend_cnt, 8);
    check("R5 req held", ref_req, 1);
    check("R4 target held", ref_dimm * 256 + ref_rank * 16 + ref_bank, 0);
    man_gnt = 1'b1;
    @(negedge clk);
    man_gnt = 1'b0;
    check("R5 pend after accept", pend_cnt, 7);
    check("R3 bank after accept", ref_bank, 1);
    auto_gnt = 1'b1;
    repeat (10) @(negedge clk);
    check("R5 pend drained", (pend_cnt <= 1) ? 1 : 0, 1);
    auto_gnt = 1'b0;

    // R7: expiry and acceptance in the same cycle
    do_reset(100, 4, 1, 2);
    @(negedge clk);
    while (pend_cnt == 0) @(negedge clk);
    repeat (11) @(negedge clk);
    p0 = pend_cnt;
    man_gnt = 1'b1;
    @(negedge clk);
    man_gnt = 1'b0;
    pn = pend_cnt;
    check("R7 pend kept", pn, p0);
    check("R7 target advanced", ref_bank, 1);
    man_gnt = 1'b1;
    @(negedge clk);
    man_gnt = 1'b0;
    check("R5 plain accept", pend_cnt, p0 - 1);
    check("R3 second advance", ref_bank, 2);

    // R2: quotient of zero forced to one, 5/128 -> one per cycle
    do_reset(5, 8, 4, 4);
    repeat (3) @(negedge clk);
    check("R2 clamp pend", pend_cnt, 3);
    repeat (10) @(negedge clk);
    check("R6 clamp saturate", pend_cnt, 8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule